// File: doc/BRIEF.md
# Privileged Tag-Control Register Access Unit

This block holds a small system register that steers memory tag allocation. Bit 16 selects the random-tag generation mode, and bits 15:0 form a mask of tag values excluded from allocation. The register sits in a 64-bit space. Only the low 17 bits exist. The upper bits always read as zero, and writes to them are dropped.

Move-to and move-from system-register requests arrive one per strobe. Each request carries a five-field encoding, the requester's privilege level (0 to 3), a write word and a read/write flag. The block answers every strobe exactly one cycle later with one of these outcomes: completed, undefined, trap to level 2, trap to level 3, or not selected. A completed read also returns the register contents. The trap check is ordered by priority. It depends on the privilege level, the tag-access enable bits of levels 2 and 3, whether those levels are present or enabled, whether they run in 64-bit state, and a debug-halt override with a configurable priority option.

Top module: `tagctl_reg_unit`

## Requirements
- R1: A completed write stores wdata[16:0]. A later completed read returns those 17 bits in rsp_rdata[16:0], and rsp_rdata[63:17] are always zero.
- R2: The register is selected only when op0=2'b11, op1=3'b000, CRn=4'b0001, CRm=4'b0000 and op2=3'b110. Any other encoding returns outcome NOSEL (code 4) and leaves the register unchanged.
- R3: Every selected access at level 0 returns UNDEF (code 1).
- R4: At level 1 the outcome is chosen by the first step that applies, in this order.
  - If halted with secure debug disabled, the priority option is set, and level 3 is present in 64-bit state with its tag enable at 0, the outcome is UNDEF.
  - Otherwise, if level 2 is enabled in 64-bit state with its tag enable at 0, the outcome is TRAP_L2 (code 2).
  - Otherwise, if level 3 is present in 64-bit state with its tag enable at 0, the outcome is UNDEF when halted with secure debug disabled, and TRAP_L3 (code 3) otherwise.
  - If no step applies, the outcome is DONE (code 0).
- R5: At level 2 the R4 sequence applies without the level-2 trap step.
- R6: Every selected access at level 3 returns DONE, whatever the other inputs are.
- R7: rsp_ec is 6'h18 with either trap outcome and 0 with every other outcome.
- R8: Reads and writes go through the same check. A write changes the register only when its outcome is DONE.
- R9: rsp_valid is high exactly in the cycle after a request strobe. rsp_rdata is zero unless the response is a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write word |
| l2_enabled | input | 1 | Level 2 is enabled |
| l2_narrow | input | 1 | Level 2 uses 32-bit state |
| l2_tag_en | input | 1 | Level-2 tag-access enable |
| l3_present | input | 1 | Level 3 is implemented |
| l3_narrow | input | 1 | Level 3 uses 32-bit state |
| l3_tag_en | input | 1 | Level-3 tag-access enable |
| dbg_halted | input | 1 | Core is in debug halt |
| dbg_sec_off | input | 1 | Secure debug disabled |
| dbg_l3_first | input | 1 | Priority option: the level-3 undefined check comes first |
| rsp_valid | output | 1 | Response strobe |
| rsp_outcome | output | 3 | 0 DONE, 1 UNDEF, 2 TRAP_L2, 3 TRAP_L3, 4 NOSEL |
| rsp_ec | output | 6 | Exception class for traps |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench sweeps all four privilege levels against all 512 settings of the nine condition inputs. Each outcome is compared with an independently written priority function. Errors this catches include:
- a design that evaluates the level-2 trap before the debug undefined check, which returns TRAP_L2 where UNDEF is required;
- a design that keeps the level-2 step at level 2;
- a design that ignores the halt override on the level-3 step, which traps instead of going undefined.

Writes are interleaved through the same sweep, so a design that writes on a trapped or undefined access corrupts later read data. Directed cases send near-miss encodings and write all-ones upper bits. A design that decodes loosely, or stores more than 17 bits, then returns a wrong outcome or non-zero upper read data.

// File: rtl/tagctl_pkg.sv
package tagctl_pkg;

    typedef enum logic [2:0] {
        OC_DONE    = 3'd0,
        OC_UNDEF   = 3'd1,
        OC_TRAP_L2 = 3'd2,
        OC_TRAP_L3 = 3'd3,
        OC_NOSEL   = 3'd4
    } outcome_e;

    // Condition inputs consumed by the privilege gate
    typedef struct packed {
        logic l2_enabled;
        logic l2_narrow;
        logic l2_tag_en;
        logic l3_present;
        logic l3_narrow;
        logic l3_tag_en;
        logic halted;
        logic sec_off;
        logic l3_first;
    } gate_cond_t;

endpackage

// File: rtl/tagctl_decode.sv
module tagctl_decode #(
    parameter logic [1:0] MATCH_OP0 = 2'b11,
    parameter logic [2:0] MATCH_OP1 = 3'b000,
    parameter logic [3:0] MATCH_CRN = 4'b0001,
    parameter logic [3:0] MATCH_CRM = 4'b0000,
    parameter logic [2:0] MATCH_OP2 = 3'b110
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    always_comb begin
        hit = (op0 == MATCH_OP0) && (op1 == MATCH_OP1) && (crn == MATCH_CRN)
           && (crm == MATCH_CRM) && (op2 == MATCH_OP2);
    end
endmodule

// File: rtl/tagctl_gate.sv
module tagctl_gate
    import tagctl_pkg::*;
#(
    parameter bit HAS_L2_STEP_AT_L1 = 1'b1
) (
    input  logic [1:0] el,
    input  gate_cond_t cond,
    output outcome_e   verdict
);
    logic l2_blocks;
    logic l3_blocks;
    logic halt_override;
    logic l2_step_live;

    always_comb begin
        l2_blocks     = cond.l2_enabled && !cond.l2_narrow && !cond.l2_tag_en;
        l3_blocks     = cond.l3_present && !cond.l3_narrow && !cond.l3_tag_en;
        halt_override = cond.halted && cond.sec_off;
        l2_step_live  = HAS_L2_STEP_AT_L1 && (el == 2'd1);

        verdict = OC_DONE;
        unique case (el)
            2'd0: verdict = OC_UNDEF;
            2'd3: verdict = OC_DONE;
            default: begin
                if (halt_override && cond.l3_first && l3_blocks) begin
                    verdict = OC_UNDEF;
                end else if (l2_step_live && l2_blocks) begin
                    verdict = OC_TRAP_L2;
                end else if (l3_blocks) begin
                    verdict = halt_override ? OC_UNDEF : OC_TRAP_L3;
                end else begin
                    verdict = OC_DONE;
                end
            end
        endcase
    end

    // A level-2 trap may only ever come from a level-1 requester
    always_comb begin
        if (el != 2'd1) begin
            AST_L2_TRAP_ONLY_L1: assert (verdict != OC_TRAP_L2); // R5
        end
    end
endmodule

// File: rtl/tagctl_reg_unit.sv
module tagctl_reg_unit
    import tagctl_pkg::*;
#(
    parameter int          DATA_W    = 64,
    parameter int          FIELD_W   = 16,
    parameter logic [5:0]  TRAP_EC   = 6'h18,
    parameter int unsigned RESET_VAL = 32'h0001_5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [1:0]        req_el,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              l2_enabled,
    input  logic              l2_narrow,
    input  logic              l2_tag_en,
    input  logic              l3_present,
    input  logic              l3_narrow,
    input  logic              l3_tag_en,
    input  logic              dbg_halted,
    input  logic              dbg_sec_off,
    input  logic              dbg_l3_first,
    output logic              rsp_valid,
    output logic [2:0]        rsp_outcome,
    output logic [5:0]        rsp_ec,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int STORE_W = FIELD_W + 1;  // exclusion mask plus mode bit
    localparam logic [STORE_W-1:0] STORE_INIT = STORE_W'(RESET_VAL);

    typedef struct packed {
        logic               valid;
        outcome_e           outcome;
        logic [5:0]         ec;
        logic [DATA_W-1:0]  rdata;
        logic [STORE_W-1:0] store;
    } unit_state_t;

    unit_state_t st_d, st_q;
    gate_cond_t  cond;
    outcome_e    verdict;
    logic        hit;
    logic        commit_wr;

    tagctl_decode u_decode (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (hit)
    );

    always_comb begin
        cond.l2_enabled = l2_enabled;
        cond.l2_narrow  = l2_narrow;
        cond.l2_tag_en  = l2_tag_en;
        cond.l3_present = l3_present;
        cond.l3_narrow  = l3_narrow;
        cond.l3_tag_en  = l3_tag_en;
        cond.halted     = dbg_halted;
        cond.sec_off    = dbg_sec_off;
        cond.l3_first   = dbg_l3_first;
    end

    tagctl_gate u_gate (
        .el      (req_el),
        .cond    (cond),
        .verdict (verdict)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = req_valid;
        st_d.outcome = OC_DONE;
        st_d.ec      = '0;
        st_d.rdata   = '0;
        commit_wr    = 1'b0;
        if (req_valid) begin
            st_d.outcome = hit ? verdict : OC_NOSEL;
            if (hit && (verdict == OC_TRAP_L2 || verdict == OC_TRAP_L3)) begin
                st_d.ec = TRAP_EC;
            end
            if (hit && verdict == OC_DONE) begin
                if (req_write) begin
                    commit_wr  = 1'b1;
                    st_d.store = req_wdata[STORE_W-1:0];
                end else begin
                    st_d.rdata = {{(DATA_W-STORE_W){1'b0}}, st_q.store};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid   <= 1'b0;
            st_q.outcome <= OC_DONE;
            st_q.ec      <= '0;
            st_q.rdata   <= '0;
            st_q.store   <= STORE_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.valid;
    assign rsp_outcome = st_q.outcome;
    assign rsp_ec      = st_q.ec;
    assign rsp_rdata   = st_q.rdata;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[DATA_W-1:STORE_W] == '0); // R1

    AST_NOSEL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (rsp_outcome == OC_NOSEL) && $stable(st_q.store)); // R2

    AST_L0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_el == 2'd0) |=> rsp_outcome == OC_UNDEF); // R3

    AST_L3_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_el == 2'd3) |=> rsp_outcome == OC_DONE); // R6

    AST_TRAP_EC: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_outcome == OC_TRAP_L2 || rsp_outcome == OC_TRAP_L3))
        |-> rsp_ec == TRAP_EC); // R7

    AST_STORE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.store) |-> $past(req_valid && req_write && hit) && rsp_outcome == OC_DONE); // R8

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9

    AST_RDATA_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> rsp_rdata == '0); // R9

endmodule

// File: tb/tagctl_reg_unit_tb_top.sv
module tagctl_reg_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b000;
    logic [3:0]  req_crn = 4'b0001;
    logic [3:0]  req_crm = 4'b0000;
    logic [2:0]  req_op2 = 3'b110;
    logic [1:0]  req_el = '0;
    logic [63:0] req_wdata = '0;
    logic [8:0]  cnd = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_outcome;
    logic [5:0]  rsp_ec;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    logic [16:0] model = '0;
    bit model_known = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    // cnd = {l3_first, sec_off, halted, l3_tag_en, l3_narrow, l3_present, l2_tag_en, l2_narrow, l2_enabled}
    tagctl_reg_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_op0      (req_op0),
        .req_op1      (req_op1),
        .req_crn      (req_crn),
        .req_crm      (req_crm),
        .req_op2      (req_op2),
        .req_el       (req_el),
        .req_wdata    (req_wdata),
        .l2_enabled   (cnd[0]),
        .l2_narrow    (cnd[1]),
        .l2_tag_en    (cnd[2]),
        .l3_present   (cnd[3]),
        .l3_narrow    (cnd[4]),
        .l3_tag_en    (cnd[5]),
        .dbg_halted   (cnd[6]),
        .dbg_sec_off  (cnd[7]),
        .dbg_l3_first (cnd[8]),
        .rsp_valid    (rsp_valid),
        .rsp_outcome  (rsp_outcome),
        .rsp_ec       (rsp_ec),
        .rsp_rdata    (rsp_rdata)
    );

    // Vector: {el[1:0], write, cnd[8:0], expected outcome[2:0]}
    localparam int NVEC = 13;
    localparam logic [14:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 9'b000000000, 3'd1},
        {2'd1, 1'b0, 9'b000000000, 3'd0},
        {2'd1, 1'b1, 9'b000000001, 3'd2},
        {2'd1, 1'b0, 9'b000000011, 3'd0},
        {2'd1, 1'b1, 9'b000001000, 3'd3},
        {2'd1, 1'b0, 9'b011001000, 3'd1},
        {2'd1, 1'b1, 9'b111001001, 3'd1},
        {2'd1, 1'b0, 9'b011001001, 3'd2},
        {2'd2, 1'b0, 9'b000000001, 3'd0},
        {2'd2, 1'b1, 9'b000001000, 3'd3},
        {2'd3, 1'b0, 9'b111001001, 3'd0},
        {2'd1, 1'b0, 9'b000101000, 3'd0},
        {2'd2, 1'b0, 9'b000011000, 3'd0}
    };

    function automatic logic [2:0] ref_outcome(input logic [1:0] el, input logic [8:0] c);
        logic l2b, l3b, hs;
        l2b = c[0] && !c[1] && !c[2];
        l3b = c[3] && !c[4] && !c[5];
        hs  = c[6] && c[7];
        if (el == 2'd0) return 3'd1;
        if (el == 2'd3) return 3'd0;
        if (hs && c[8] && l3b) return 3'd1;
        if (el == 2'd1 && l2b) return 3'd2;
        if (l3b) return hs ? 3'd1 : 3'd3;
        return 3'd0;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one request on a falling edge; results are read one cycle later
    task automatic issue(input logic [1:0] el, input logic wr, input logic [8:0] c,
                         input logic [63:0] wd);
        @(negedge clk);
        req_el    = el;
        req_write = wr;
        cnd       = c;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check_resp(input string req, input logic [2:0] exp_oc, input logic wr);
        logic [63:0] exp_rd;
        exp_rd = (exp_oc == 3'd0 && !wr && model_known) ? {47'd0, model} : 64'd0;
        check(req, "valid", {63'd0, rsp_valid}, 64'd1);
        check(req, "outcome", {61'd0, rsp_outcome}, {61'd0, exp_oc});
        check("R7", "ec", {58'd0, rsp_ec},
              (exp_oc == 3'd2 || exp_oc == 3'd3) ? 64'h18 : 64'h0);
        if (model_known || wr || exp_oc != 3'd0)
            check("R9", "rdata", rsp_rdata, exp_rd);
        check("R1", "upper zero", {47'd0, rsp_rdata[63:17]} , 64'd0);
        if (wr && exp_oc == 3'd0) begin
            model = req_wdata[16:0];
            model_known = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "valid idle after reset", {63'd0, rsp_valid}, 64'd0);

        // Seed a known value at level 3 with all-ones upper bits (R1, R6)
        issue(2'd3, 1'b1, 9'b111001001, 64'hFFFF_FFFF_FFFE_A5C3);
        check_resp("R6", 3'd0, 1'b1);
        issue(2'd3, 1'b0, 9'b0, 64'd0);
        check_resp("R1", 3'd0, 1'b0);
        check("R1", "stored value", rsp_rdata, 64'h0000_0000_0000_A5C3);

        // Table of directed vectors (R3, R4, R5, R6, R8)
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][14:13], VEC[i][12], VEC[i][11:3], 64'h5A5A_0000_0001_3C3C + 64'(i));
            check_resp("R4", VEC[i][2:0], VEC[i][12]);
        end

        // Exhaustive sweep against the reference priority function (R3-R8)
        for (int el = 0; el < 4; el++) begin
            for (int c = 0; c < 512; c++) begin
                logic wr;
                wr = c[0] ^ c[4] ^ el[0];
                issue(2'(el), wr, 9'(c), 64'hFFFF_0000_0000_0000 | 64'(c * 40503 + el * 977));
                check_resp(el == 0 ? "R3" : el == 1 ? "R4" : el == 2 ? "R5" : "R6",
                           ref_outcome(2'(el), 9'(c)), wr);
            end
        end

        // Trapped write leaves register unchanged (R8)
        issue(2'd1, 1'b1, 9'b000000001, 64'h0000_0000_0000_1111);
        check_resp("R8", 3'd2, 1'b1);
        issue(2'd3, 1'b0, 9'b0, 64'd0);
        check_resp("R8", 3'd0, 1'b0);

        // Near-miss encodings: NOSEL and no write (R2)
        req_op2 = 3'b111;
        issue(2'd3, 1'b1, 9'b0, 64'h0000_0000_0001_0000);
        check("R2", "op2 miss outcome", {61'd0, rsp_outcome}, 64'd4);
        check("R2", "op2 miss ec", {58'd0, rsp_ec}, 64'd0);
        req_op2 = 3'b110;
        req_op0 = 2'b10;
        issue(2'd3, 1'b1, 9'b0, 64'h0000_0000_0000_0000);
        check("R2", "op0 miss outcome", {61'd0, rsp_outcome}, 64'd4);
        req_op0 = 2'b11;
        req_crn = 4'b0011;
        issue(2'd0, 1'b0, 9'b0, 64'd0);
        check("R2", "crn miss beats level 0", {61'd0, rsp_outcome}, 64'd4);
        req_crn = 4'b0001;
        issue(2'd3, 1'b0, 9'b0, 64'd0);
        check_resp("R2", 3'd0, 1'b0);

        // Response lasts one cycle only (R9)
        @(negedge clk);
        check("R9", "valid drops", {63'd0, rsp_valid}, 64'd0);

        finish_run();
    end

endmodule